// File: doc/BRIEF.md
# Infrared Carrier Square-Wave Generator

This block produces the square-wave carrier that an infrared remote-control transmitter needs. A 6-bit up-counter advances on one of four internal reference ticks. The ticks are taken from a free-running prescaler at power-of-two divisions of the system clock. Two programmed values shape the wave. The period value sets where the counter wraps. The high-width value sets how many counts of each cycle the output stays high.

Software writes the configuration through a small register write port. A single control register carries both the reference select and the high width. A second register carries the period, and a third carries the enable. The carrier can be routed onto a pad that otherwise drives an ordinary general-purpose output bit, and a plain select input chooses between the two. There is no data stream at the edge of this block, so every port is a plain control or status pin and none uses a valid/ready handshake.

Top module: `ir_carrier_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `carrier_o` is 0. All registers clear to 0, so the block comes out of reset disabled.
- R2: The counter steps at most once per reference tick. With reference select s, a tick happens on each cycle in which the low s bits of a free-running prescaler are all ones. The prescaler clears at reset and increments every clock, so the counter advances once every 2^s clocks.
- R3: With the block enabled, the counter runs 0, 1, ... up to the period value P, then returns to 0 on the next tick. One carrier cycle therefore lasts (P+1) ticks, and the count never exceeds P.
- R4: `carrier_o` is 1 exactly while the block is enabled and the count is below the high width W. With W = 0 the output stays low. With W > P the output stays high.
- R5: When the enable is 0, the counter is held at 0 and `carrier_o` is 0.
- R6: A new high width, period or reference select that is written while the block runs takes effect only at the next counter wrap. While the block is disabled, the new values take effect on the following cycle.
- R7: The register map is as follows. Address 0 holds the reference select in bits [7:6] and the high width in bits [5:0]. Address 1 holds the period in bits [5:0]. Address 2 holds the enable in bit 0. A write to address 3 has no effect.
- R8: `pad_o` equals `carrier_o` when `pin_sel_i` is 1, and equals `gpio_i` when `pin_sel_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| pin_sel_i | input | 1 | 1 routes the carrier onto the pad |
| gpio_i | input | 1 | General-purpose value for the pad |
| carrier_o | output | 1 | Carrier square wave |
| pad_o | output | 1 | Shared pad output |

## Verification
Two events can fall in the same clock edge: a configuration write and a counter wrap. If the write lands on the wrap edge, the wrap must load the old values and the new ones must wait a full cycle. The bench provokes this case by rewriting the width and period at every offset of a running cycle, under several reference selects. A behavioural model applies the counter update before the write at each edge. The model is compared with both outputs on every clock.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;
  typedef enum logic [1:0] {
    REG_SHAPE  = 2'd0,
    REG_PERIOD = 2'd1,
    REG_ENABLE = 2'd2,
    REG_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/ir_ref_taps.sv
module ir_ref_taps #(
  parameter int SEL_W    = 2,
  parameter int TAP_STEP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int NUM_REF = 1 << SEL_W;
  localparam int PRE_W   = (NUM_REF - 1) * TAP_STEP;

  logic [PRE_W-1:0]   pre_q;
  logic [NUM_REF-1:0] taps;

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_REF; k++) begin : g_tap
    if (k == 0) begin : g_full
      assign taps[k] = 1'b1;
    end else begin : g_div
      assign taps[k] = &pre_q[k*TAP_STEP-1:0];
    end
  end

  assign tick_o = taps[sel_i];
endmodule

// File: rtl/ir_cfg_regs.sv
module ir_cfg_regs
  import ir_carrier_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int SEL_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [1:0]             addr_i,
  input  logic [CNT_W+SEL_W-1:0] wdata_i,
  output logic [CNT_W-1:0]       width_o,
  output logic [CNT_W-1:0]       period_o,
  output logic [SEL_W-1:0]       sel_o,
  output logic                   en_o
);
  localparam int DATA_W = CNT_W + SEL_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width_o  <= '0;
      period_o <= '0;
      sel_o    <= '0;
      en_o     <= 1'b0;
    end else if (we_i) begin
      case (reg_addr_e'(addr_i))
        REG_SHAPE: begin
          sel_o   <= wdata_i[DATA_W-1:CNT_W];
          width_o <= wdata_i[CNT_W-1:0];
        end
        REG_PERIOD: period_o <= wdata_i[CNT_W-1:0];
        REG_ENABLE: en_o     <= wdata_i[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ir_carrier_core.sv
module ir_carrier_core #(
  parameter int CNT_W = 6,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] sel_act_o,
  output logic             carrier_o
);
  logic [CNT_W-1:0] cnt_q, width_act, period_act;
  logic             wrap;

  assign wrap = en_i && tick_i && (cnt_q == period_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      width_act  <= '0;
      period_act <= '0;
      sel_act_o  <= '0;
    end else if (!en_i || wrap) begin
      cnt_q      <= '0;
      width_act  <= width_i;
      period_act <= period_i;
      sel_act_o  <= sel_i;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign carrier_o = en_i && (cnt_q < width_act);

  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= period_act);
  assert_step_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !tick_i) |=> $stable(cnt_q));
  assert_held_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));
  assert_zero_width_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (width_act == '0) |-> !carrier_o);
  assert_shape_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !wrap) |=> ($stable(width_act) && $stable(period_act)));
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
  parameter int CNT_W    = 6,
  parameter int SEL_W    = 2,
  parameter int TAP_STEP = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we_i,
  input  logic [1:0]             cfg_addr_i,
  input  logic [CNT_W+SEL_W-1:0] cfg_wdata_i,
  input  logic                   pin_sel_i,
  input  logic                   gpio_i,
  output logic                   carrier_o,
  output logic                   pad_o
);
  logic [CNT_W-1:0] width_s, period_s;
  logic [SEL_W-1:0] sel_s, sel_act;
  logic             en_s, tick;

  ir_cfg_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .width_o(width_s), .period_o(period_s),
    .sel_o(sel_s), .en_o(en_s)
  );

  ir_ref_taps #(.SEL_W(SEL_W), .TAP_STEP(TAP_STEP)) u_taps (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_act), .tick_o(tick)
  );

  ir_carrier_core #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_core (
    .clk(clk), .rst_n(rst_n), .en_i(en_s), .tick_i(tick),
    .width_i(width_s), .period_i(period_s), .sel_i(sel_s),
    .sel_act_o(sel_act), .carrier_o(carrier_o)
  );

  assign pad_o = pin_sel_i ? carrier_o : gpio_i;

  assert_pad_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pin_sel_i |-> (pad_o == carrier_o));
  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |=> !carrier_o);
endmodule

// File: tb/test_ir_carrier_gen.sv
module test_ir_carrier_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       pin_sel = 1'b0;
  logic       gpio = 1'b0;
  logic       carrier, pad;

  int checks = 0, failures = 0, cyc = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // behavioural model state
  int m_pre = 0, m_cnt = 0, m_w = 0, m_p = 0, m_s = 0;
  int s_w = 0, s_p = 0, s_s = 0;
  bit m_en = 0;

  always #2.5 clk = ~clk;

  ir_carrier_gen i_ir_carrier_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .pin_sel_i(pin_sel), .gpio_i(gpio),
    .carrier_o(carrier), .pad_o(pad)
  );

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_w = 0; m_p = 0; m_s = 0;
      s_w = 0; s_p = 0; s_s = 0; m_en = 0;
    end else begin
      bit tk;
      int div;
      div = 1 << m_s;
      tk = ((m_pre % div) == div - 1);
      if (!m_en) begin
        m_cnt = 0; m_w = s_w; m_p = s_p; m_s = s_s;
      end else if (tk) begin
        if (m_cnt == m_p) begin
          m_cnt = 0; m_w = s_w; m_p = s_p; m_s = s_s;
        end else m_cnt = m_cnt + 1;
      end
      m_pre = (m_pre + 1) % 8;
      if (we) begin
        case (addr)
          2'd0: begin s_s = wdata[7:6]; s_w = wdata[5:0]; end
          2'd1: s_p = wdata[5:0];
          2'd2: m_en = wdata[0];
          default: ;
        endcase
      end
    end
  end

  function automatic bit exp_carrier();
    return m_en && (m_cnt < m_w);
  endfunction

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s got=%0d expected=%0d (cycle %0d)", req, what, got, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "carrier", carrier, exp_carrier());
      check("R8", "pad", pad, pin_sel ? exp_carrier() : gpio);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // count high cycles across a window
  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (carrier) hi++;
    end
  endtask

  initial begin
    int hi;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "carrier in reset", carrier, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "carrier after reset", carrier, 0);

    // R8: pad follows gpio when not selected
    cur_req = "R8";
    gpio = 1'b1; @(negedge clk); check("R8", "pad=gpio 1", pad, 1);
    gpio = 1'b0; @(negedge clk); check("R8", "pad=gpio 0", pad, 0);
    pin_sel = 1'b1;

    // R3/R4: sel 0, width 3, period 7 -> 3 high of every 8
    cur_req = "R3";
    wr(2'd0, {2'd0, 6'd3});
    wr(2'd1, 8'd7);
    wr(2'd2, 8'd1);
    idle(3);
    count_high(32, hi);
    check("R3", "high cycles in 4 periods", hi, 12);

    // R5: disable holds low
    cur_req = "R5";
    wr(2'd2, 8'd0);
    count_high(20, hi);
    check("R5", "high cycles while off", hi, 0);

    // R2: sel 2, width 2, period 3 -> period 16 clocks, high 8
    cur_req = "R2";
    wr(2'd0, {2'd2, 6'd2});
    wr(2'd1, 8'd3);
    wr(2'd2, 8'd1);
    idle(40);
    count_high(64, hi);
    check("R2", "high cycles over 4 divided periods", hi, 32);

    // R4: zero width and oversize width
    cur_req = "R4";
    wr(2'd2, 8'd0);
    wr(2'd0, {2'd1, 6'd0});
    wr(2'd2, 8'd1);
    count_high(30, hi);
    check("R4", "zero width stays low", hi, 0);
    wr(2'd2, 8'd0);
    wr(2'd0, {2'd0, 6'd63});
    wr(2'd1, 8'd5);
    wr(2'd2, 8'd1);
    count_high(30, hi);
    check("R4", "width above period stays high", hi, 30);

    // R6: rewrite shape at every offset, under each select
    cur_req = "R6";
    for (int s = 0; s < 4; s++) begin
      for (int off = 0; off < 12; off++) begin
        wr(2'd2, 8'd0);
        wr(2'd0, {s[1:0], 6'd2});
        wr(2'd1, 8'd4);
        wr(2'd2, 8'd1);
        idle(off);
        wr(2'd0, {s[1:0], 6'd5});
        wr(2'd1, 8'd7);
        idle(6);
        wr(2'd0, {2'(3 - s), 6'd1});
        idle(40);
      end
    end

    // R7: address 3 has no effect
    cur_req = "R7";
    wr(2'd2, 8'd0);
    wr(2'd0, {2'd0, 6'd2});
    wr(2'd1, 8'd3);
    wr(2'd2, 8'd1);
    idle(5);
    wr(2'd3, 8'hFF);
    idle(3);
    count_high(16, hi);
    check("R7", "addr 3 write leaves 2-of-4 duty", hi, 8);

    // R8: pad again with select off while running
    pin_sel = 1'b0; gpio = 1'b1;
    @(negedge clk); check("R8", "pad=gpio while running", pad, 1);
    pin_sel = 1'b1;
    idle(4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    failures++;
    done = 1'b1;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule